// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a programmable interval timer that sits on a small word-addressed register bus. A down-counter, whose width is a parameter (16 or 32 bits in practice), moves one step for each pulse of a selected tick-enable input. Two tick-enable inputs stand in for a slow and a fast reference clock, and a control bit chooses between them. When the counter passes zero it either reloads from the load register (periodic mode) or wraps to all ones (free mode). Every such underflow sets a level-high interrupt that stays set until software writes anything to the clear register.

The usual setup is to write the control register with the run bit clear, write the load register with N-1 for a period of N ticks, and then set the run bit. A separate 40-bit up-counter advances on its own tick-enable input whenever bit 8 of its upper word is set. It never raises an interrupt, and its low 32 bits read back as one word.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset every readable register returns 0 and `irq` is low.
- R2: The down-counter (read at word 1) drops by one on each selected tick while run (control bit 7) is set. It holds its value while bit 7 is clear.
- R3: Control bit 3 set selects `tick_fast`, and bit 3 clear selects `tick_slow`. Pulses on the unselected input leave the counter unchanged.
- R4: In periodic mode (control bit 6 set), a tick at count 0 reloads the count from the load register (word 0). A load value of N-1 therefore gives an underflow every N ticks.
- R5: In free mode (control bit 6 clear), a tick at count 0 wraps the count to all ones.
- R6: Each underflow sets `irq`, which stays high until any value is written to the clear register (word 3). An underflow in the same cycle as a clear leaves `irq` set. Word 3 always reads 0.
- R7: A write to the load register (word 0) puts the written value into the counter on the next edge, whether the timer is running or stopped. This takes priority over a tick in the same cycle.
- R8: Writes to the value register (word 1) have no effect.
- R9: Only control bits 7, 6 and 3 are stored. The control register (word 2) reads back those bits and zeros elsewhere.
- R10: The 40-bit counter advances by one per `tick_free` pulse while bit 8 of word 5 is set, and holds while that bit is clear. Word 4 reads its low 32 bits. Word 5 reads its top 8 bits in bits 7:0 and the enable in bit 8. The counter never affects `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow tick-enable for the down-counter |
| tick_fast | input | 1 | Fast tick-enable for the down-counter |
| tick_free | input | 1 | Tick-enable for the 40-bit up-counter |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Sticky level-high underflow interrupt |

## Verification
The bench builds the block with an 8-bit down-counter. This brings the all-ones wrap of free mode and the largest load value, 255 (a 256-tick period), within a few hundred ticks. It sweeps the period across load values 0 to 11 plus 199 and 255, counting ticks up to each interrupt. The narrow width also makes it cheap to reach the same-cycle collisions: clear against underflow, and load against tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int BUS_AW      = 3;
    localparam int BUS_DW      = 32;
    localparam int RUN_BIT     = 7;
    localparam int PERIODIC_BIT = 6;
    localparam int FAST_BIT    = 3;
    localparam int FREE_EN_BIT = 8;

    typedef enum logic [BUS_AW-1:0] {
        RS_LOAD  = 3'd0,
        RS_VALUE = 3'd1,
        RS_CTRL  = 3'd2,
        RS_CLEAR = 3'd3,
        RS_FLO   = 3'd4,
        RS_FHI   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic periodic;
        logic fast;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_DW-1:0] w);
        ctrl_t c;
        c.run      = w[RUN_BIT];
        c.periodic = w[PERIODIC_BIT];
        c.fast     = w[FAST_BIT];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[RUN_BIT]      = c.run;
        w[PERIODIC_BIT] = c.periodic;
        w[FAST_BIT]     = c.fast;
        return w;
    endfunction

endpackage

// File: rtl/tt_downctr.sv
module tt_downctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         periodic,
    input  logic         load_wr,
    input  logic [W-1:0] load_now,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         uflow
);

    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign uflow   = tick && run && !load_wr && at_zero;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_now;
        end else if (tick && run) begin
            if (at_zero)
                cnt_q <= periodic ? reload_val : '1;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/tt_irqlatch.sv
module tt_irqlatch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);

    logic irq_q;
    assign irq = irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (set)
            irq_q <= 1'b1;
        else if (clr)
            irq_q <= 1'b0;
    end

endmodule

// File: rtl/tt_freectr.sv
module tt_freectr #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick && en)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FREE_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              tick_free,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);

    localparam int FHI_W = FREE_W - BUS_DW;

    reg_sel_e          sel_e;
    logic              wr_en;
    logic              load_wr;
    logic              ctrl_wr;
    logic              clr_wr;
    logic              fhi_wr;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cnt_val;
    logic              tick_sel;
    logic              uflow;
    logic              free_en_q;
    logic [FREE_W-1:0] free_cnt;
    logic              unused_wdata;

    assign sel_e   = reg_sel_e'(bus_addr);
    assign wr_en   = bus_sel && bus_wr;
    assign load_wr = wr_en && (sel_e == RS_LOAD);
    assign ctrl_wr = wr_en && (sel_e == RS_CTRL);
    assign clr_wr  = wr_en && (sel_e == RS_CLEAR);
    assign fhi_wr  = wr_en && (sel_e == RS_FHI);
    assign unused_wdata = ^bus_wdata;

    assign tick_sel = ctrl_q.fast ? tick_fast : tick_slow;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            load_q    <= '0;
            free_en_q <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_from_word(bus_wdata);
            if (load_wr)
                load_q <= bus_wdata[CNT_W-1:0];
            if (fhi_wr)
                free_en_q <= bus_wdata[FREE_EN_BIT];
        end
    end

    tt_downctr #(.W(CNT_W)) u_down (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_sel),
        .run        (ctrl_q.run),
        .periodic   (ctrl_q.periodic),
        .load_wr    (load_wr),
        .load_now   (bus_wdata[CNT_W-1:0]),
        .reload_val (load_q),
        .cnt        (cnt_val),
        .uflow      (uflow)
    );

    tt_irqlatch u_irq (
        .clk (clk),
        .rst (rst),
        .set (uflow),
        .clr (clr_wr),
        .irq (irq)
    );

    tt_freectr #(.W(FREE_W)) u_free (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_free),
        .en   (free_en_q),
        .cnt  (free_cnt)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel_e)
            RS_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
            RS_VALUE: bus_rdata[CNT_W-1:0] = cnt_val;
            RS_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
            RS_FLO:   bus_rdata = free_cnt[BUS_DW-1:0];
            RS_FHI: begin
                bus_rdata[FHI_W-1:0]    = free_cnt[FREE_W-1:BUS_DW];
                bus_rdata[FREE_EN_BIT]  = free_en_q;
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int FREE_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              run,
    input logic              periodic,
    input logic              tick_sel,
    input logic              load_wr,
    input logic              clr_wr,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_q,
    input logic [31:0]       bus_wdata,
    input logic [2:0]        bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              free_en,
    input logic              tick_free,
    input logic [FREE_W-1:0] free_cnt
);

    logic at_uflow;
    assign at_uflow = run && tick_sel && !load_wr && (cnt == '0);

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_wr |=> irq); // R6

    AST_UFLOW_RAISES: assert property (@(posedge clk) disable iff (rst)
        at_uflow |=> irq); // R6

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr == 3'd3 |-> bus_rdata == 32'd0); // R6

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run && !load_wr |=> $stable(cnt)); // R2

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        at_uflow && periodic |=> cnt == $past(load_q)); // R4

    AST_WRAP_ONES: assert property (@(posedge clk) disable iff (rst)
        at_uflow && !periodic |=> cnt == {CNT_W{1'b1}}); // R5

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> cnt == $past(bus_wdata[CNT_W-1:0])); // R7

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (rst)
        free_en && tick_free |=> free_cnt == $past(free_cnt) + FREE_W'(1)); // R10

    AST_FREE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(free_en && tick_free) |=> $stable(free_cnt)); // R10

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .run       (ctrl_q.run),
    .periodic  (ctrl_q.periodic),
    .tick_sel  (tick_sel),
    .load_wr   (load_wr),
    .clr_wr    (clr_wr),
    .cnt       (cnt_val),
    .load_q    (load_q),
    .bus_wdata (bus_wdata),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .free_en   (free_en_q),
    .tick_free (tick_free),
    .free_cnt  (free_cnt)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam int CW = 8;
    localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2,
                           A_CLR = 3'd3, A_FLO = 3'd4, A_FHI = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_free = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_timer #(.CNT_W(CW), .FREE_W(40)) uut (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .tick_free(tick_free), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_slow = 1'b1;
            @(negedge clk); tick_slow = 1'b0;
        end
    endtask

    task automatic pulse_fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_fast = 1'b1;
            @(negedge clk); tick_fast = 1'b0;
        end
    endtask

    task automatic pulse_free(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_free = 1'b1;
            @(negedge clk); tick_free = 1'b0;
        end
    endtask

    task automatic period_case(input int n);
        logic [31:0] v;
        wr(A_CTRL, 32'h40);
        wr(A_CLR, 32'h0);
        wr(A_LOAD, n - 1);
        wr(A_CTRL, 32'hC0);
        pulse_slow(n - 1);
        rd(A_VAL, v); check("R4 count at zero before underflow", v, 0);
        check("R6 no irq before underflow", irq, 0);
        pulse_slow(1);
        check("R6 irq after N ticks", irq, 1);
        rd(A_VAL, v); check("R4 reload value", v, n - 1);
        wr(A_CLR, 32'hDEAD_BEEF);
        check("R6 clear drops irq", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v); check("R1 reset read", v, 0);
        end
        check("R1 reset irq", irq, 0);

        // R9 control storage
        wr(A_CTRL, 32'h48);
        rd(A_CTRL, v); check("R9 ctrl 0x48", v, 32'h48);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R9 ctrl only bits 7,6,3", v, 32'hC8);
        wr(A_CTRL, 32'h48);

        // R7 load while stopped, R2 hold while stopped
        wr(A_LOAD, 5);
        rd(A_VAL, v); check("R7 load while stopped", v, 5);
        rd(A_LOAD, v); check("R7 load readback", v, 5);
        pulse_slow(3); pulse_fast(3);
        rd(A_VAL, v); check("R2 hold while stopped", v, 5);

        // R8 value register read-only
        wr(A_VAL, 32'h33);
        rd(A_VAL, v); check("R8 value write ignored", v, 5);

        // R3 tick select, R2 count down
        wr(A_CTRL, 32'hC8);
        pulse_slow(2);
        rd(A_VAL, v); check("R3 slow ignored in fast mode", v, 5);
        pulse_fast(1);
        rd(A_VAL, v); check("R2 decrement on fast tick", v, 4);
        wr(A_CTRL, 32'hC0);
        pulse_fast(2);
        rd(A_VAL, v); check("R3 fast ignored in slow mode", v, 4);
        pulse_slow(1);
        rd(A_VAL, v); check("R2 decrement on slow tick", v, 3);

        // R4 period sweep
        for (int n = 1; n <= 12; n++) period_case(n);
        period_case(200);
        period_case(256);

        // R6 sticky across further underflows
        wr(A_CTRL, 32'h40); wr(A_LOAD, 2); wr(A_CTRL, 32'hC0);
        pulse_slow(3);
        check("R6 irq set", irq, 1);
        pulse_slow(4);
        check("R6 irq stays set", irq, 1);
        rd(A_CLR, v); check("R6 clear reads zero", v, 0);
        wr(A_CLR, 32'h0);
        check("R6 write of zero clears", irq, 0);

        // R6 underflow and clear in the same cycle
        wr(A_LOAD, 0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
        tick_slow = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_slow = 1'b0;
        check("R6 underflow beats clear", irq, 1);
        wr(A_CLR, 32'h0);

        // R7 load beats a same-cycle tick while running
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_LOAD; bus_wdata = 32'd9;
        tick_slow = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_slow = 1'b0;
        rd(A_VAL, v); check("R7 load beats tick", v, 9);
        check("R7 no underflow on load", irq, 0);
        pulse_slow(1);
        rd(A_VAL, v); check("R2 count after load", v, 8);

        // R5 free mode wrap
        wr(A_CTRL, 32'h80); wr(A_LOAD, 1);
        pulse_slow(1);
        rd(A_VAL, v); check("R5 reach zero", v, 0);
        pulse_slow(1);
        rd(A_VAL, v); check("R5 wrap to all ones", v, 32'hFF);
        check("R6 irq on wrap", irq, 1);
        pulse_slow(1);
        rd(A_VAL, v); check("R5 continue after wrap", v, 32'hFE);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h0);

        // R10 free counter
        pulse_free(5);
        rd(A_FLO, v); check("R10 hold while disabled", v, 0);
        wr(A_FHI, 32'h100);
        rd(A_FHI, v); check("R10 enable readback", v, 32'h100);
        pulse_free(37);
        rd(A_FLO, v); check("R10 count up", v, 37);
        check("R10 no irq", irq, 0);
        wr(A_FHI, 32'h0);
        pulse_free(3);
        rd(A_FLO, v); check("R10 hold after disable", v, 37);
        wr(A_FHI, 32'h1FF);
        rd(A_FHI, v); check("R10 only enable stored", v, 32'h100);
        rd(A_VAL, v); check("R10 down-counter untouched", v, 32'hFE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule